// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte per finished transmit frame, oldest first, and shows the oldest waiting byte on a byte-wide read port. The transmit engine reports each completion with a one-cycle strobe, three error flags (jabber, underrun, maximum collisions) and a per-frame bit asking for an interrupt on success. Software reads the head byte and removes it by writing the port, which this block sees as a one-cycle pop strobe.

A jabber or underrun leaves the transmitter in a state that needs a transmit reset. The block raises a reset-required flag and discards further completions until the reset strobe arrives. A transmit-complete event goes to the command/status unit whenever a stored entry either carries an error or asked for an interrupt.

Top module: `tx_status_stack`

## Requirements
- R1: A stored byte has bit 7 = 1 (complete), bit 6 = interrupt-on-success request, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow (set later, see R4), and bits 1..0 = 0. On `cpl_err_i`, bit 2 is jabber, bit 1 is underrun and bit 0 is maximum collisions.
- R2: `stat_byte_o` shows the oldest stored byte, and shows 8'h00 when the stack is empty. After reset the stack is empty.
- R3: A `stat_pop_i` pulse removes the oldest entry, so the next oldest appears after the following clock edge. A pop on an empty stack has no effect.
- R4: The stack holds DEPTH (default 4) entries. If a completion arrives while the stack is full and no pop happens in the same cycle, the completion is dropped and bit 2 of the newest stored entry is set. If a pop happens in the same cycle, the new completion is stored.
- R5: A completion with jabber or underrun that is accepted (see R6) sets `tx_reset_req_o` from the next cycle. This holds even if the byte itself is dropped by R4.
- R6: While `tx_reset_req_o` is high, completions are ignored. The stack contents do not change, except through pops.
- R7: `tx_reset_i` empties the stack and clears `tx_reset_req_o` at the next edge. It takes priority over a completion or a pop in the same cycle.
- R8: `tx_done_evt_o` is high while any stored entry has bit 6, 5, 4 or 3 set. A stored entry for a successful frame that did not request an interrupt does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpl_valid_i | input | 1 | Completion strobe from the transmit engine |
| cpl_err_i | input | 3 | {jabber, underrun, max collisions} for this completion |
| cpl_intr_req_i | input | 1 | Frame asked for an interrupt on success |
| stat_pop_i | input | 1 | Host write to the status port; pops the head entry |
| tx_reset_i | input | 1 | Transmit reset strobe |
| stat_byte_o | output | 8 | Oldest status byte, or 0 when empty |
| tx_done_evt_o | output | 1 | Transmit-complete event to the command/status unit |
| tx_reset_req_o | output | 1 | A transmit reset is required |

## Verification
Directed runs come first. Single completions with each error flag and with the interrupt request separate the bit positions and show which entries raise the event. A fill-and-drain run checks the order and the empty-read value. Five completions with no pop separate the overflow marking from a plain drop, and a push with a pop at full shows the push is accepted. A jabber followed by more completions and a reset, with push and pop in the reset cycle, checks the ignore window and the reset priority. A long pseudo-random mix of completions, pops and resets is then compared every cycle against a queue model. This finds ordering and boundary mistakes that the directed runs do not reach.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
  localparam int STAT_W = 8;
  localparam int B_DONE = 7;
  localparam int B_IREQ = 6;
  localparam int B_JAB  = 5;
  localparam int B_UND  = 4;
  localparam int B_MCOL = 3;
  localparam int B_OVF  = 2;

  typedef logic [STAT_W-1:0] stat_t;

  function automatic stat_t pack_stat(input logic ireq, input logic jab,
                                      input logic und, input logic mcol);
    stat_t s;
    s         = '0;
    s[B_DONE] = 1'b1;
    s[B_IREQ] = ireq;
    s[B_JAB]  = jab;
    s[B_UND]  = und;
    s[B_MCOL] = mcol;
    return s;
  endfunction
endpackage

// File: rtl/tx_stat_fifo.sv
module tx_stat_fifo
  import tx_stat_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic                          push_i,
  input  stat_t                         push_data_i,
  input  logic                          pop_i,
  output stat_t                         head_o,
  output logic [DEPTH-1:0][STAT_W-1:0]  ent_o,
  output logic [DEPTH-1:0]              occ_o,
  output logic                          full_o,
  output logic                          empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0][STAT_W-1:0] mem_q;
  logic [DEPTH-1:0]             occ_q;
  logic [PTR_W-1:0]             wr_q, rd_q, newest;
  logic                         pop_eff, push_ok, ovf_mark;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty_o  = ~|occ_q;
  assign full_o   = &occ_q;
  assign pop_eff  = pop_i && !empty_o;
  assign push_ok  = push_i && (!full_o || pop_i);
  assign ovf_mark = push_i && full_o && !pop_i;
  assign newest   = (wr_q == '0) ? LAST : wr_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      occ_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else if (clear_i) begin
      occ_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (pop_eff) begin
        occ_q[rd_q] <= 1'b0;
        rd_q        <= nxt(rd_q);
      end
      if (push_ok) begin
        mem_q[wr_q] <= push_data_i;
        occ_q[wr_q] <= 1'b1;
        wr_q        <= nxt(wr_q);
      end else if (ovf_mark) begin
        mem_q[newest][B_OVF] <= 1'b1;
      end
    end
  end

  assign head_o = empty_o ? '0 : mem_q[rd_q];
  assign ent_o  = mem_q;
  assign occ_o  = occ_q;

  assert_pop_shrinks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i && !clear_i)
      |=> ($countones(occ_o) == $countones($past(occ_o)) - 1));

  assert_full_drop_marks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clear_i)
      |=> ($stable(occ_o) && mem_q[$past(newest)][B_OVF]));

  assert_head_layout_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o |-> (head_o[B_DONE] && head_o[1:0] == 2'b00));
endmodule

// File: rtl/tx_stat_event.sv
module tx_stat_event
  import tx_stat_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0][STAT_W-1:0] ent_i,
  input  logic [DEPTH-1:0]             occ_i,
  output logic                         evt_o
);
  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign hit[g] = occ_i[g] & (ent_i[g][B_IREQ] | ent_i[g][B_JAB] |
                                ent_i[g][B_UND]  | ent_i[g][B_MCOL]);
  end

  assign evt_o = |hit;
endmodule

// File: rtl/tx_status_stack.sv
module tx_status_stack
  import tx_stat_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpl_valid_i,
  input  logic [2:0] cpl_err_i,
  input  logic       cpl_intr_req_i,
  input  logic       stat_pop_i,
  input  logic       tx_reset_i,
  output logic [7:0] stat_byte_o,
  output logic       tx_done_evt_o,
  output logic       tx_reset_req_o
);
  logic                         rreq_q, accept, fatal;
  stat_t                        new_stat;
  logic [DEPTH-1:0][STAT_W-1:0] ent;
  logic [DEPTH-1:0]             occ;
  logic                         full, empty;

  assign accept   = cpl_valid_i && !rreq_q && !tx_reset_i;
  assign fatal    = cpl_err_i[2] | cpl_err_i[1];
  assign new_stat = pack_stat(cpl_intr_req_i, cpl_err_i[2], cpl_err_i[1], cpl_err_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rreq_q <= 1'b0;
    else if (tx_reset_i)        rreq_q <= 1'b0;
    else if (accept && fatal)   rreq_q <= 1'b1;
  end

  tx_stat_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (tx_reset_i),
    .push_i      (accept),
    .push_data_i (new_stat),
    .pop_i       (stat_pop_i),
    .head_o      (stat_byte_o),
    .ent_o       (ent),
    .occ_o       (occ),
    .full_o      (full),
    .empty_o     (empty)
  );

  tx_stat_event #(.DEPTH(DEPTH)) i_event (
    .ent_i (ent),
    .occ_i (occ),
    .evt_o (tx_done_evt_o)
  );

  assign tx_reset_req_o = rreq_q;

  assert_reset_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_reset_i |=> (!tx_reset_req_o && stat_byte_o == 8'h00 && !tx_done_evt_o));

  assert_fatal_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_i && !tx_reset_req_o && !tx_reset_i && fatal) |=> tx_reset_req_o);

  assert_ignore_while_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_reset_req_o && !tx_reset_i)
      |=> ($countones(occ) <= $countones($past(occ))));

  assert_evt_needs_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_evt_o |-> !empty);

  assert_flag_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_reset_req_o && !tx_reset_i) |=> tx_reset_req_o);

  logic unused_full;
  assign unused_full = full;
endmodule

// File: tb/test_tx_status_stack.sv
module test_tx_status_stack;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpl_valid = 1'b0;
  logic [2:0] cpl_err = 3'b000;
  logic       cpl_ireq = 1'b0;
  logic       pop = 1'b0;
  logic       trst = 1'b0;
  logic [7:0] stat_byte;
  logic       done_evt, reset_req;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  string phase = "R2";

  logic [7:0] q[$];
  logic       m_rreq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_status_stack #(.DEPTH(DEPTH)) i_tx_status_stack (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cpl_valid_i    (cpl_valid),
    .cpl_err_i      (cpl_err),
    .cpl_intr_req_i (cpl_ireq),
    .stat_pop_i     (pop),
    .tx_reset_i     (trst),
    .stat_byte_o    (stat_byte),
    .tx_done_evt_o  (done_evt),
    .tx_reset_req_o (reset_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Model of R1..R8, applied once per clock edge
  task automatic model(input logic v, input logic [2:0] e, input logic ir,
                       input logic p, input logic tr);
    logic [7:0] b;
    if (tr) begin
      q.delete();
      m_rreq = 1'b0;
    end else begin
      if (p && q.size() > 0) void'(q.pop_front());
      if (v && !m_rreq) begin
        b = {1'b1, ir, e[2], e[1], e[0], 3'b000};
        if (q.size() < DEPTH) q.push_back(b);
        else q[q.size()-1][2] = 1'b1;
        if (e[2] || e[1]) m_rreq = 1'b1;
      end
    end
  endtask

  task automatic compare();
    logic [7:0] exp_b;
    logic       exp_e;
    exp_b = (q.size() > 0) ? q[0] : 8'h00;
    exp_e = 1'b0;
    foreach (q[i]) if (|q[i][6:3]) exp_e = 1'b1;
    check(stat_byte == exp_b, phase, stat_byte, exp_b);
    check(done_evt == exp_e, "R8", done_evt, exp_e);
    check(reset_req == m_rreq, "R5", reset_req, m_rreq);
  endtask

  task automatic step(input logic v, input logic [2:0] e, input logic ir,
                      input logic p, input logic tr);
    cpl_valid = v; cpl_err = e; cpl_ireq = ir; pop = p; trst = tr;
    @(posedge clk);
    model(v, e, ir, p, tr);
    @(negedge clk);
    compare();
    cpl_valid = 1'b0; cpl_err = 3'b000; cpl_ireq = 1'b0; pop = 1'b0; trst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R2";
    compare();  // reset state: empty, no event, no reset request

    // R1: field layout for each flag, one at a time
    phase = "R1";
    step(1, 3'b000, 1, 0, 0); step(0, 3'b000, 0, 1, 0);
    step(1, 3'b001, 0, 0, 0); step(0, 3'b000, 0, 1, 0);
    step(1, 3'b000, 0, 0, 0); step(0, 3'b000, 0, 1, 0); // R8: quiet success
    step(1, 3'b001, 1, 0, 0); step(0, 3'b000, 0, 1, 0);

    // R3: ordering, pop on empty
    phase = "R3";
    step(1, 3'b000, 1, 0, 0);
    step(1, 3'b001, 0, 0, 0);
    step(1, 3'b000, 0, 0, 0);
    step(0, 3'b000, 0, 1, 0);
    step(0, 3'b000, 0, 1, 0);
    step(0, 3'b000, 0, 1, 0);
    step(0, 3'b000, 0, 1, 0);

    // R4: overflow marking, then push with pop at full
    phase = "R4";
    for (int i = 0; i < DEPTH; i++) step(1, 3'b000, i[0], 0, 0);
    step(1, 3'b001, 0, 0, 0);
    step(1, 3'b000, 1, 1, 0);
    for (int i = 0; i < DEPTH + 1; i++) step(0, 3'b000, 0, 1, 0);

    // R5, R6: jabber sets flag, later completions ignored
    phase = "R6";
    step(1, 3'b000, 0, 0, 0);
    step(1, 3'b100, 0, 0, 0);
    step(1, 3'b000, 1, 0, 0);
    step(1, 3'b010, 0, 0, 0);
    step(0, 3'b000, 0, 1, 0);

    // R7: reset wins over same-cycle push and pop
    phase = "R7";
    step(1, 3'b000, 1, 1, 1);
    step(1, 3'b000, 1, 0, 0);
    for (int i = 0; i < DEPTH; i++) step(1, 3'b010, 0, 0, 0);
    step(1, 3'b000, 0, 1, 1);

    // R2: pseudo-random mix
    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] e;
      e[2] = ($urandom % 24) == 0;
      e[1] = ($urandom % 24) == 0;
      e[0] = ($urandom % 4) == 0;
      step(($urandom % 2) == 0, e, ($urandom % 3) == 0,
           ($urandom % 3) == 0, ($urandom % 20) == 0);
    end

    finish_run();
  end
endmodule